// File: doc/BRIEF.md
# Register-Pair Double-Word Load/Store Sequencer

This block carries out one 64-bit load or store between an even/odd pair of general registers and a 32-bit memory port. A start strobe captures the base value, a signed 16-bit displacement, the even register number and, for stores, the contents of both registers of the pair. The sequencer then issues two word accesses, one after the other. Each access holds its request until the memory acknowledges it. Loads are returned as two single-word register-file writes.

The effective address is the base plus the sign-extended displacement, with the two low bits cleared. The pair maps onto memory in inverted order. The odd (higher-numbered) register goes to the effective address and the even register goes to the word above it. Loads fetch the lower word first. Stores write the upper word first. A short form takes zero as the base. An odd register number is refused with a one-cycle error pulse and makes no memory access.

Top module: `pair_access_seq`

## Requirements
- R1: After reset, and with no start, mem_req_o, mem_we_o, busy_o, done_o, pair_err_o and rf_we_o are all 0.
- R2: Every access address is derived from the effective address EA = base + sign-extended offs_i with bits [1:0] forced to 0. When zero_base_i is 1 at start, base is 0; otherwise base is base_i. The two accesses of one operation use EA and EA+4.
- R3: For a load (store_i = 0), the first access reads EA and the second reads EA+4, both with mem_we_o = 0.
- R4: For a load, the word read at EA is written to register reg_idx_i+1 and the word read at EA+4 is written to register reg_idx_i. Each write (rf_we_o pulse with rf_waddr_o/rf_wdata_o) appears in the cycle after the acknowledge of its read, which is one load-delay cycle.
- R5: For a store (store_i = 1), the first access writes st_even_i (the data of register reg_idx_i) to EA+4. The second writes st_odd_i (the data of register reg_idx_i+1) to EA. Both accesses have mem_we_o = 1.
- R6: Once raised, mem_req_o stays high with mem_addr_o, mem_we_o and mem_wdata_o unchanged until a cycle in which mem_ack_i is 1.
- R7: A start with an odd reg_idx_i raises pair_err_o for exactly the next cycle. It issues no memory request and leaves busy_o low.
- R8: busy_o rises in the cycle after an accepted start and falls in the cycle after the second acknowledge. A start asserted while busy_o is 1 is ignored and issues no further access.
- R9: done_o pulses for one cycle, in the cycle after the second acknowledge.
- R10: A store never asserts rf_we_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for one double-word operation |
| store_i | input | 1 | 1 = store, 0 = load |
| zero_base_i | input | 1 | Use 0 as the base instead of base_i |
| base_i | input | 32 | Base value |
| offs_i | input | 16 | Signed displacement |
| reg_idx_i | input | 5 | Even register number of the pair |
| st_even_i | input | 32 | Store data of register reg_idx_i |
| st_odd_i | input | 32 | Store data of register reg_idx_i+1 |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Word address of the access |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access completes this cycle |
| mem_rdata_i | input | 32 | Read data, valid with mem_ack_i |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_waddr_o | output | 5 | Register-file write index |
| rf_wdata_o | output | 32 | Register-file write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation finished |
| pair_err_o | output | 1 | Odd register number refused |

## Verification
The assertions assume that mem_ack_i is only raised while mem_req_o is high. They also assume mem_rdata_i is valid in that same cycle, so that a write-back can always be traced to a read acknowledge. The bench acts as the memory and keeps to this contract. It drives mem_ack_i only after it has seen mem_req_o high at a falling edge, and it drops the acknowledge at the next falling edge. Wait states of zero to two cycles are inserted to exercise the request hold. A stray start is pulsed only during wait cycles, so it lands while busy_o is high.

// File: rtl/pair_seq_pkg.sv
package pair_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC0 = 2'd1,
    ST_ACC1 = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/pair_addr_gen.sv
module pair_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 16,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFFS_W-1:0] offs_i,
  input  logic              hi_sel_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int AL         = $clog2(WORD_BYTES);

  logic [ADDR_W-1:0] sum, ea;

  assign sum    = base_i + {{(ADDR_W-OFFS_W){offs_i[OFFS_W-1]}}, offs_i};
  assign ea     = {sum[ADDR_W-1:AL], {AL{1'b0}}};
  assign addr_o = hi_sel_i ? ea + ADDR_W'(WORD_BYTES) : ea;
endmodule

// File: rtl/pair_seq_fsm.sv
module pair_seq_fsm
  import pair_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       idx_odd_i,
  input  logic       ack_i,
  output seq_state_e state_o,
  output logic       accept_o,
  output logic       err_o
);
  seq_state_e state_q, state_d;
  logic       open_q;
  logic       err_q;

  assign open_q   = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign accept_o = start_i && open_q && !idx_odd_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: state_d = accept_o ? ST_ACC0 : ST_IDLE;
      ST_ACC0:          if (ack_i) state_d = ST_ACC1;
      ST_ACC1:          if (ack_i) state_d = ST_DONE;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= start_i && open_q && idx_odd_i;
    end
  end

  assign state_o = state_q;
  assign err_o   = err_q;

  // accesses only follow an accepted start
  p_acc_entry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACC0) && $past(state_q != ST_ACC0) |-> $past(start_i && !idx_odd_i));
  p_err_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> !err_q || $past(start_i));
endmodule

// File: rtl/pair_rf_wb.sv
module pair_rf_wb #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [REG_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              we_o,
  output logic [REG_W-1:0]  waddr_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic              we_q;
  logic [REG_W-1:0]  waddr_q;
  logic [DATA_W-1:0] wdata_q;

  // one register stage = load-delay slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      we_q <= cap_i;
      if (cap_i) begin
        waddr_q <= waddr_i;
        wdata_q <= wdata_i;
      end
    end
  end

  assign we_o    = we_q;
  assign waddr_o = waddr_q;
  assign wdata_o = wdata_q;
endmodule

// File: rtl/pair_access_seq.sv
module pair_access_seq
  import pair_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFFS_W = 16,
  parameter int REG_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              store_i,
  input  logic              zero_base_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFFS_W-1:0] offs_i,
  input  logic [REG_W-1:0]  reg_idx_i,
  input  logic [DATA_W-1:0] st_even_i,
  input  logic [DATA_W-1:0] st_odd_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rf_we_o,
  output logic [REG_W-1:0]  rf_waddr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              pair_err_o
);
  localparam int AL = $clog2(DATA_W / 8);

  seq_state_e        state;
  logic              accept;
  logic              store_q;
  logic [ADDR_W-1:0] base_q;
  logic [OFFS_W-1:0] offs_q;
  logic [REG_W-1:0]  idx_q;
  logic [DATA_W-1:0] even_q, odd_q;
  logic              active, hi_sel;
  logic [REG_W-1:0]  wb_idx;

  pair_seq_fsm i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .idx_odd_i (reg_idx_i[0]),
    .ack_i     (mem_ack_i),
    .state_o   (state),
    .accept_o  (accept),
    .err_o     (pair_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_q <= 1'b0;
      base_q  <= '0;
      offs_q  <= '0;
      idx_q   <= '0;
      even_q  <= '0;
      odd_q   <= '0;
    end else if (accept) begin
      store_q <= store_i;
      base_q  <= zero_base_i ? '0 : base_i;
      offs_q  <= offs_i;
      idx_q   <= reg_idx_i;
      even_q  <= st_even_i;
      odd_q   <= st_odd_i;
    end
  end

  assign active = (state == ST_ACC0) || (state == ST_ACC1);
  // upper word first for stores, lower word first for loads
  assign hi_sel = store_q ^ (state == ST_ACC1);

  pair_addr_gen #(
    .ADDR_W (ADDR_W),
    .OFFS_W (OFFS_W),
    .DATA_W (DATA_W)
  ) i_addr (
    .base_i   (base_q),
    .offs_i   (offs_q),
    .hi_sel_i (hi_sel),
    .addr_o   (mem_addr_o)
  );

  assign mem_req_o   = active;
  assign mem_we_o    = active && store_q;
  assign mem_wdata_o = mem_we_o ? (hi_sel ? even_q : odd_q) : '0;
  // upper word pairs with the even register
  assign wb_idx      = hi_sel ? idx_q : {idx_q[REG_W-1:1], 1'b1};

  pair_rf_wb #(
    .DATA_W (DATA_W),
    .REG_W  (REG_W)
  ) i_wb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (active && mem_ack_i && !store_q),
    .waddr_i (wb_idx),
    .wdata_i (mem_rdata_i),
    .we_o    (rf_we_o),
    .waddr_o (rf_waddr_o),
    .wdata_o (rf_wdata_o)
  );

  assign busy_o = active;
  assign done_o = (state == ST_DONE);

  p_req_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
                                && $stable(mem_we_o) && $stable(mem_wdata_o));
  p_addr_align_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[AL-1:0] == '0);
  p_err_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_err_o |-> !mem_req_o && !busy_o);
  p_wb_follows_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> $past(mem_req_o && mem_ack_i && !mem_we_o));
  p_store_no_wb_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_ack_i |=> !rf_we_o);
  p_done_after_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_req_o && mem_ack_i) && !busy_o);
  p_busy_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !mem_ack_i |=> busy_o);
endmodule

// File: tb/test_pair_access_seq.sv
`timescale 1ns/1ps
module test_pair_access_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, store = 1'b0, zbase = 1'b0;
  logic [31:0] base = '0;
  logic [15:0] offs = '0;
  logic [4:0]  idx = '0;
  logic [31:0] d_even = '0, d_odd = '0;
  logic        req, we, ack = 1'b0;
  logic [31:0] addr, wdata, rdata = '0;
  logic        rf_we, busy, done, err;
  logic [4:0]  rf_waddr;
  logic [31:0] rf_wdata;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pair_access_seq i_pair_access_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .store_i(store),
    .zero_base_i(zbase), .base_i(base), .offs_i(offs), .reg_idx_i(idx),
    .st_even_i(d_even), .st_odd_i(d_odd),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_ack_i(ack), .mem_rdata_i(rdata),
    .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .busy_o(busy), .done_o(done), .pair_err_o(err)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return a ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one memory access as seen from the port; called at a falling edge
  task automatic serve(input logic [31:0] e_addr, input logic e_we, input logic [31:0] e_wdata,
                       input int waits, input logic poke);
    for (int w = 0; w < waits; w++) begin
      chk(req == 1'b1, "R6 req held", {31'b0, req}, 32'd1);
      chk(addr == e_addr, "R6 addr stable", addr, e_addr);
      if (poke) begin
        start = 1'b1; idx = 5'd2; zbase = 1'b1; offs = 16'h0100; store = ~store;
      end
      @(negedge clk);
      start = 1'b0;
    end
    chk(req == 1'b1, "R6 req at ack", {31'b0, req}, 32'd1);
    chk(addr == e_addr, e_we ? "R5 addr" : "R3 addr", addr, e_addr);
    chk(we == e_we, e_we ? "R5 we" : "R3 we", {31'b0, we}, {31'b0, e_we});
    if (e_we) chk(wdata == e_wdata, "R5 wdata", wdata, e_wdata);
    ack = 1'b1;
    rdata = mem_word(addr);
    @(negedge clk);
    ack = 1'b0;
    rdata = '0;
  endtask

  task automatic run_op(input logic st, input logic zb, input logic [31:0] b, input logic [15:0] o,
                        input logic [4:0] r, input logic [31:0] de, input logic [31:0] dodd,
                        input int waits, input logic poke);
    logic [31:0] ea, ea4, sum;
    sum = (zb ? 32'd0 : b) + {{16{o[15]}}, o};
    ea  = {sum[31:2], 2'b00};
    ea4 = ea + 32'd4;
    store = st; zbase = zb; base = b; offs = o; idx = r; d_even = de; d_odd = dodd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", {31'b0, busy}, 32'd1);
    if (st) serve(ea4, 1'b1, de, waits, poke);
    else    serve(ea, 1'b0, '0, waits, poke);
    chk(busy == 1'b1, "R8 busy between accesses", {31'b0, busy}, 32'd1);
    if (st) chk(rf_we == 1'b0, "R10 no write-back", {31'b0, rf_we}, 32'd0);
    else begin
      chk(rf_we == 1'b1, "R4 first write strobe", {31'b0, rf_we}, 32'd1);
      chk(rf_waddr == (r | 5'd1), "R4 first write index", {27'b0, rf_waddr}, {27'b0, r | 5'd1});
      chk(rf_wdata == mem_word(ea), "R4 first write data", rf_wdata, mem_word(ea));
    end
    if (st) serve(ea, 1'b1, dodd, waits, poke);
    else    serve(ea4, 1'b0, '0, waits, poke);
    chk(done == 1'b1, "R9 done pulse", {31'b0, done}, 32'd1);
    chk(busy == 1'b0, "R8 busy falls", {31'b0, busy}, 32'd0);
    if (st) chk(rf_we == 1'b0, "R10 no write-back", {31'b0, rf_we}, 32'd0);
    else begin
      chk(rf_we == 1'b1, "R4 second write strobe", {31'b0, rf_we}, 32'd1);
      chk(rf_waddr == r, "R4 second write index", {27'b0, rf_waddr}, {27'b0, r});
      chk(rf_wdata == mem_word(ea4), "R4 second write data", rf_wdata, mem_word(ea4));
    end
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", {31'b0, done}, 32'd0);
    chk(req == 1'b0, "R8 no extra access", {31'b0, req}, 32'd0);
    chk(rf_we == 1'b0, "R4 no third write", {31'b0, rf_we}, 32'd0);
  endtask

  task automatic t_reset;
    chk(!req && !we && !busy && !done && !err && !rf_we, "R1 reset outputs",
        {26'b0, req, we, busy, done, err, rf_we}, 32'd0);
  endtask

  task automatic t_odd_reg;
    store = 1'b0; zbase = 1'b0; base = 32'h4000; offs = 16'h0; idx = 5'd7;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b1, "R7 error pulse", {31'b0, err}, 32'd1);
    chk(req == 1'b0, "R7 no request", {31'b0, req}, 32'd0);
    chk(busy == 1'b0, "R7 not busy", {31'b0, busy}, 32'd0);
    @(negedge clk);
    chk(err == 1'b0, "R7 error one cycle", {31'b0, err}, 32'd0);
    chk(req == 1'b0, "R7 still no request", {31'b0, req}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    // R3 R4 plain load, aligned, no wait states
    run_op(1'b0, 1'b0, 32'h0000_1000, 16'h0008, 5'd4, '0, '0, 0, 1'b0);
    // R2 negative offset, misaligned sum, wait states
    run_op(1'b0, 1'b0, 32'h0000_2007, 16'hFFFE, 5'd12, '0, '0, 2, 1'b0);
    // R5 R8 R10 store with stray starts while busy
    run_op(1'b1, 1'b0, 32'h0000_3000, 16'h0011, 5'd10, 32'hEEEE_0001, 32'hD0D0_0002, 1, 1'b1);
    // R2 short form: base ignored
    run_op(1'b0, 1'b1, 32'hDEAD_0000, 16'h7FFC, 5'd30, '0, '0, 0, 1'b0);
    // R5 store, zero waits, short form
    run_op(1'b1, 1'b1, 32'h1234_5678, 16'h0043, 5'd0, 32'h0000_AAAA, 32'h0000_5555, 0, 1'b0);
    t_odd_reg();
    t_reset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule